// File: doc/BRIEF.md
# Windowed Key-Code Watchdog Timer

The block is a watchdog built on an up counter that advances once per tick of a selectable prescaler. Software keeps it alive by writing an eight-bit service key to a command register. A service write is accepted only inside a window. The window opens at a selectable fraction of the counter range and stays open until the tick that would wrap the counter. A service write that comes too early counts as a malfunction. So does a wrap of the counter.

On a malfunction the block sends one of two one-cycle requests. It sends a reset request or an interrupt request, chosen by a bit of the control register. A second key stops the watchdog, but only while the control enable bit is clear. Software can read the live counter value, the control register and a status register. The status register shows whether the watchdog runs and holds a sticky interrupt flag that a status read clears.

Registers sit at word addresses 0 (control, read/write), 1 (command, write only), 2 (counter, read only) and 3 (status, read only). The control byte holds:
- bits [1:0]: tick select
- bits [3:2]: window select
- bit 4: output select (1 = reset request)
- bit 5: enable

Read data is registered and appears one cycle after the read strobe. It reads 0 in any cycle without a read.

Top module: `kwdog_top`

## Requirements
- R1: After reset, control reads 0x34, status reads 0x01 (running, no interrupt pending), the counter reads 0, and both request outputs are low.
- R2: While running, the counter advances by one every 2^(2+2*tap) clock cycles, where tap is control bits [1:0]. A control write restarts the prescaler phase, and address 2 returns the counter value.
- R3: When the counter holds 255 and a tick arrives with no service write, it wraps to 0 and a malfunction is raised.
- R4: Writing 0x4E to the command register while the counter is at or above the window opening clears the counter and its prescaler phase, with no malfunction.
- R5: Writing 0x4E while the counter is below the window opening clears the counter and raises a malfunction.
- R6: A 0x4E write in the same cycle as the wrap tick clears the counter and raises no malfunction.
- R7: A malfunction gives a one-cycle pulse on the next clock. The pulse goes on wdt_rst_req when control bit 4 is 1, and otherwise on wdt_irq_req, which also sets status bit 1. The two outputs are never high together.
- R8: A read of status returns the interrupt flag and clears it, unless a new interrupt sets it in the same cycle.
- R9: Writing 0xB1 to the command register stops the watchdog (status bit 0 goes to 0, the counter holds, no malfunctions) only when control bit 5 is 0. With bit 5 set, the write has no effect.
- R10: A command write of any value other than 0x4E or 0xB1 changes neither the counter nor the run state.
- R11: Window select 0, 1, 2 and 3 open the window at counter values 64, 128, 192 and 224 respectively.
- R12: A control write with bit 5 set restarts a stopped watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| wdt_rst_req | output | 1 | One-cycle reset request |
| wdt_irq_req | output | 1 | One-cycle interrupt request |

## Verification
A corrupted counter or prescaler phase shows up at address 2 on the very next read. It also shifts the wrap pulse by whole tick periods, which the cycle-level comparison catches on the cycle the pulse is expected. A wrong window threshold or a wrong run flag reveals itself as an extra or a missing request pulse on the clock right after the offending service write. A stale interrupt flag appears on the second of two back-to-back status reads.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;

   localparam logic [7:0] KEY_SERVICE = 8'h4E;
   localparam logic [7:0] KEY_STOP    = 8'hB1;

   typedef enum logic [1:0] {
      A_CTRL = 2'd0,
      A_CMD  = 2'd1,
      A_CNT  = 2'd2,
      A_STAT = 2'd3
   } reg_addr_e;

   typedef struct packed {
      logic       en;
      logic       out_rst;
      logic [1:0] win;
      logic [1:0] tap;
   } ctrl_t;

   localparam ctrl_t CTRL_INIT = '{en: 1'b1, out_rst: 1'b1, win: 2'b01, tap: 2'b00};

endpackage

// File: rtl/kwdog_presc.sv
module kwdog_presc #(
   parameter int TAP_BASE = 2,
   parameter int TAP_STEP = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic [1:0] tap_sel,
   output logic       tick
);
   localparam int NUM_TAPS = 4;
   localparam int PRESC_W  = TAP_BASE + TAP_STEP * (NUM_TAPS - 1);

   generate
      if (TAP_BASE < 1 || TAP_STEP < 1) begin : g_bad_tap
         $error("kwdog_presc: TAP_BASE and TAP_STEP must be at least 1");
      end
   endgenerate

   logic [PRESC_W-1:0]  phase_q;
   logic [NUM_TAPS-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase_q <= '0;
      else if (restart) phase_q <= '0;
      else              phase_q <= phase_q + 1'b1;
   end

   for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
      localparam int TW = TAP_BASE + TAP_STEP * i;
      assign hit[i] = &phase_q[TW-1:0];
   end

   assign tick = hit[tap_sel];

endmodule

// File: rtl/kwdog_core.sv
module kwdog_core #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             running,
   input  logic             svc_key,
   input  logic [1:0]       win_sel,
   output logic [CNT_W-1:0] cnt,
   output logic             fault
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] OPEN_Q1 = CNT_W'(1) << (CNT_W - 2);
   localparam logic [CNT_W-1:0] OPEN_H  = CNT_W'(1) << (CNT_W - 1);
   localparam logic [CNT_W-1:0] OPEN_Q3 = CNT_W'(3) << (CNT_W - 2);
   localparam logic [CNT_W-1:0] OPEN_E7 = CNT_W'(7) << (CNT_W - 3);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] open_at;
   logic             wrap, early;

   always_comb begin
      case (win_sel)
         2'd0:    open_at = OPEN_Q1;
         2'd1:    open_at = OPEN_H;
         2'd2:    open_at = OPEN_Q3;
         default: open_at = OPEN_E7;
      endcase
   end

   assign wrap  = running && tick && (cnt_q == CNT_MAX) && !svc_key;
   assign early = running && svc_key && (cnt_q < open_at);
   assign fault = wrap || early;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (svc_key)          cnt_q <= '0;
      else if (running && tick)  cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/kwdog_regs.sv
module kwdog_regs
   import kwdog_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [1:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   input  logic [CNT_W-1:0] cnt,
   input  logic             fault,
   output ctrl_t            ctrl,
   output logic             running,
   output logic             svc_key,
   output logic             presc_restart,
   output logic             irq_stat,
   output logic [7:0]       rdata,
   output logic             rst_req,
   output logic             irq_req
);
   ctrl_t ctrl_q;
   logic  run_q, irq_q;
   logic  ctrl_wr, cmd_wr, stop_key, stat_rd, irq_set;

   assign ctrl_wr       = bus_wr && (bus_addr == A_CTRL);
   assign cmd_wr        = bus_wr && (bus_addr == A_CMD);
   assign svc_key       = cmd_wr && (bus_wdata == KEY_SERVICE);
   assign stop_key      = cmd_wr && (bus_wdata == KEY_STOP);
   assign stat_rd       = bus_rd && (bus_addr == A_STAT);
   assign presc_restart = svc_key || ctrl_wr;
   assign irq_set       = fault && !ctrl_q.out_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= CTRL_INIT;
      else if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata[5:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          run_q <= 1'b1;
      else if (ctrl_wr && bus_wdata[5])    run_q <= 1'b1;
      else if (stop_key && !ctrl_q.en)     run_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq_q <= 1'b0;
      else if (irq_set) irq_q <= 1'b1;
      else if (stat_rd) irq_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req <= 1'b0;
         irq_req <= 1'b0;
      end else begin
         rst_req <= fault && ctrl_q.out_rst;
         irq_req <= irq_set;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else if (bus_rd) begin
         case (bus_addr)
            A_CTRL:  rdata <= {2'b00, ctrl_q};
            A_CNT:   rdata <= 8'(cnt);
            A_STAT:  rdata <= {6'd0, irq_q, run_q};
            default: rdata <= '0;
         endcase
      end else begin
         rdata <= '0;
      end
   end

   assign ctrl     = ctrl_q;
   assign running  = run_q;
   assign irq_stat = irq_q;

endmodule

// File: rtl/kwdog_top.sv
module kwdog_top
   import kwdog_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int TAP_BASE = 2,
   parameter int TAP_STEP = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [1:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       wdt_rst_req,
   output logic       wdt_irq_req
);
   generate
      if (CNT_W < 4 || CNT_W > 8) begin : g_bad_width
         $error("kwdog_top: CNT_W must lie in 4..8");
      end
   endgenerate

   ctrl_t            ctrl;
   logic             running, svc_key, presc_restart, irq_stat;
   logic             tick, fault;
   logic [CNT_W-1:0] cnt_q;

   kwdog_presc #(.TAP_BASE(TAP_BASE), .TAP_STEP(TAP_STEP)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (presc_restart),
      .tap_sel (ctrl.tap),
      .tick    (tick)
   );

   kwdog_core #(.CNT_W(CNT_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .running (running),
      .svc_key (svc_key),
      .win_sel (ctrl.win),
      .cnt     (cnt_q),
      .fault   (fault)
   );

   kwdog_regs #(.CNT_W(CNT_W)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_wr        (bus_wr),
      .bus_rd        (bus_rd),
      .bus_addr      (bus_addr),
      .bus_wdata     (bus_wdata),
      .cnt           (cnt_q),
      .fault         (fault),
      .ctrl          (ctrl),
      .running       (running),
      .svc_key       (svc_key),
      .presc_restart (presc_restart),
      .irq_stat      (irq_stat),
      .rdata         (bus_rdata),
      .rst_req       (wdt_rst_req),
      .irq_req       (wdt_irq_req)
   );

endmodule

// File: rtl/kwdog_chk.sv
module kwdog_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             running,
   input logic             svc_key,
   input logic [CNT_W-1:0] cnt,
   input logic             rst_req,
   input logic             irq_req,
   input logic             irq_stat
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   p_one_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rst_req, irq_req}));

   p_irq_flags_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_stat);

   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !svc_key |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

   p_service_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      svc_key |=> (cnt == '0));

   p_wrap_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (running && tick && cnt == CNT_MAX && !svc_key) |=> (rst_req || irq_req));

   p_tie_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_key && cnt == CNT_MAX) |=> !(rst_req || irq_req));

   p_stopped_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !svc_key) |=> $stable(cnt));

   p_stopped_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !svc_key) |=> !(rst_req || irq_req));

endmodule

bind kwdog_top kwdog_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .running  (running),
   .svc_key  (svc_key),
   .cnt      (cnt_q),
   .rst_req  (wdt_rst_req),
   .irq_req  (wdt_irq_req),
   .irq_stat (irq_stat)
);

// File: tb/tb_kwdog_top.sv
module tb_kwdog_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       wdt_rst_req, wdt_irq_req;

   int n_checks = 0;
   int n_fail   = 0;
   int n_rst    = 0;
   int n_irq    = 0;
   int cycles   = 0;
   bit done     = 0;

   // behavioural reference state
   int m_presc, m_cnt, m_run, m_ctrl, m_irqst, m_rst, m_irq, m_rdata;

   kwdog_top dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wdt_rst_req(wdt_rst_req), .wdt_irq_req(wdt_irq_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int open_at(int w);
      case (w)
         0: return 64;
         1: return 128;
         2: return 192;
         default: return 224;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_presc = 0; m_cnt = 0; m_run = 1; m_ctrl = 'h34;
         m_irqst = 0; m_rst = 0; m_irq = 0; m_rdata = 0;
      end else begin
         int period, tick, svc, stop, cwr, fault, outsel, nrd;
         period = 1 << (2 + 2 * (m_ctrl & 3));
         tick   = ((m_presc % period) == period - 1);
         svc    = bus_wr && bus_addr == 1 && bus_wdata == 8'h4E;
         stop   = bus_wr && bus_addr == 1 && bus_wdata == 8'hB1;
         cwr    = bus_wr && bus_addr == 0;
         outsel = (m_ctrl >> 4) & 1;
         fault  = m_run && ((tick && m_cnt == 255 && !svc) ||
                            (svc && m_cnt < open_at((m_ctrl >> 2) & 3)));
         nrd = 0;
         if (bus_rd) begin
            case (bus_addr)
               0: nrd = m_ctrl;
               2: nrd = m_cnt;
               3: nrd = m_irqst * 2 + m_run;
               default: nrd = 0;
            endcase
         end
         m_rdata = nrd;
         m_rst = fault && outsel;
         m_irq = fault && !outsel;
         if (fault && !outsel) m_irqst = 1;
         else if (bus_rd && bus_addr == 3) m_irqst = 0;
         if (svc) m_cnt = 0;
         else if (m_run && tick) m_cnt = (m_cnt + 1) % 256;
         m_presc = (svc || cwr) ? 0 : (m_presc + 1) % 256;
         if (cwr && bus_wdata[5]) m_run = 1;
         else if (stop && !((m_ctrl >> 5) & 1)) m_run = 0;
         if (cwr) m_ctrl = bus_wdata & 8'h3F;
      end
   end

   // per-cycle comparison against the reference, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_rst += int'(wdt_rst_req);
         n_irq += int'(wdt_irq_req);
         n_checks++;
         if (bus_rdata != 8'(m_rdata)) begin
            n_fail++;
            $display("FAIL R2 read data: actual %0h expected %0h", bus_rdata, m_rdata);
         end
         n_checks++;
         if (wdt_rst_req != 1'(m_rst) || wdt_irq_req != 1'(m_irq)) begin
            n_fail++;
            $display("FAIL R7 requests: actual rst=%0b irq=%0b expected rst=%0d irq=%0d",
                     wdt_rst_req, wdt_irq_req, m_rst, m_irq);
         end
      end
   end

   task automatic chk(string tag, int got, int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic wr_now(logic [1:0] a, logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      wr_now(a, d);
   endtask

   task automatic rd(logic [1:0] a, output int v);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      v = int'(bus_rdata);
   endtask

   task automatic wait_cnt(int v);
      do @(negedge clk); while (m_cnt != v);
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG_CYCLES && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
         end
      end
   end

   initial begin
      int v, a, b, r0, i0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd2, v); chk("R1 counter after reset", v, 0);
      rd(2'd0, v); chk("R1 control after reset", v, 'h34);
      rd(2'd3, v); chk("R1 status after reset", v, 1);
      chk("R1 no request after reset", n_rst + n_irq, 0);

      // R4 legal service inside the window
      r0 = n_rst;
      wait_cnt(130); wr(2'd1, 8'h4E); settle();
      chk("R4 legal service no pulse", n_rst - r0, 0);
      rd(2'd2, v); chk("R4 counter cleared", int'(v < 3), 1);

      // R5 early service
      r0 = n_rst;
      wait_cnt(10); wr(2'd1, 8'h4E); settle();
      chk("R5 early service pulse", n_rst - r0, 1);

      // R3 wrap with reset output
      r0 = n_rst;
      wait_cnt(255); wait_cnt(0); settle();
      chk("R3 wrap raises reset request", n_rst - r0, 1);

      // R7 / R8 interrupt output path
      wr(2'd0, 8'h24);
      r0 = n_rst; i0 = n_irq;
      wait_cnt(255); wait_cnt(0); settle();
      chk("R7 interrupt pulse", n_irq - i0, 1);
      chk("R7 no reset pulse", n_rst - r0, 0);
      rd(2'd3, v); chk("R7 status flag set", v, 3);
      rd(2'd3, v); chk("R8 flag cleared by read", v, 1);

      // R6 service in the wrap cycle
      wr(2'd0, 8'h34);
      r0 = n_rst;
      do @(negedge clk); while (!(m_cnt == 255 && (m_presc % 4) == 3));
      wr_now(2'd1, 8'h4E); settle();
      chk("R6 tie raises nothing", n_rst - r0, 0);
      rd(2'd2, v); chk("R6 counter cleared", int'(v < 3), 1);

      // R11 window thresholds
      wr(2'd0, 8'h3C);
      r0 = n_rst;
      wait_cnt(200); wr(2'd1, 8'h4E); settle();
      chk("R11 sel3 at 200 is early", n_rst - r0, 1);
      r0 = n_rst;
      wait_cnt(230); wr(2'd1, 8'h4E); settle();
      chk("R11 sel3 at 230 is legal", n_rst - r0, 0);
      wr(2'd0, 8'h30);
      r0 = n_rst;
      wait_cnt(70); wr(2'd1, 8'h4E); settle();
      chk("R11 sel0 at 70 is legal", n_rst - r0, 0);
      r0 = n_rst;
      wait_cnt(60); wr(2'd1, 8'h4E); settle();
      chk("R11 sel0 at 60 is early", n_rst - r0, 1);

      // R9 stop key ignored while enable set; R10 other values ignored
      wr(2'd0, 8'h34);
      wr(2'd1, 8'hB1);
      rd(2'd3, v); chk("R9 stop ignored when enabled", v & 1, 1);
      r0 = n_rst;
      wait_cnt(100); wr(2'd1, 8'h55);
      rd(2'd2, v); chk("R10 other key leaves counter", int'(v >= 100), 1);
      rd(2'd3, v); chk("R10 other key leaves run", v & 1, 1);
      chk("R10 other key no pulse", n_rst - r0, 0);

      // R9 stop with enable clear
      wr(2'd0, 8'h14);
      wr(2'd1, 8'hB1);
      rd(2'd3, v); chk("R9 stopped status", v, 0);
      rd(2'd2, a);
      r0 = n_rst;
      repeat (1200) @(negedge clk);
      rd(2'd2, b); chk("R9 counter holds", b, a);
      chk("R9 no pulse while stopped", n_rst - r0, 0);

      // R12 restart
      wr(2'd0, 8'h34);
      rd(2'd3, v); chk("R12 restarted", v & 1, 1);

      // R2 slower tick: 16 cycles per count
      wr(2'd0, 8'h35);
      rd(2'd2, a);
      repeat (62) @(negedge clk);
      rd(2'd2, b);
      chk("R2 four counts in 64 cycles", (b - a) & 'hFF, 4);

      settle();
      finish_run();
   end

endmodule